// File: doc/BRIEF.md
# Program Word Parity Checker

This block sits beside the instruction fetch path and checks each fetched program word against the two parity bits stored with it. The word is split into two interleaved lanes. One lane holds the even bit positions and the other holds the odd bit positions. Each lane has its own parity bit and its own parity sense. The even lane uses even parity. The odd lane uses odd parity, so its stored bit is inverted before the comparison.

When a valid fetch fails either lane, the block raises a one-cycle reset request. In the same cycle it raises a strobe that drives the parity-error status flag to 0. The flag itself lives elsewhere, and software sets it back to 1. The block does not record which word failed. A configuration input turns checking off entirely. Reset sequencing after the request is handled outside the block.

The block also carries a parity generator function in its package. This function produces correct stored bits for a given word and is not used by the checking logic.

Top module: `pwpar_check`

## Requirements
- R1: The even lane covers bit positions 0, 2, 4, 6, 8, 10 and 12. The XOR of those seven bits with `par_even` must be 0. A nonzero result marks the fetch as failing.
- R2: The odd lane covers bit positions 1, 3, 5, 7, 9, 11 and 13. The XOR of those seven bits with the inverted `par_odd` must be 0. A nonzero result marks the fetch as failing.
- R3: A word whose `par_even` equals the XOR of its even-position bits, and whose `par_odd` equals the inverse of the XOR of its odd-position bits, produces no reset request.
- R4: A fetch is checked only in a cycle where `fetch_vld` is 1. Failing data presented while `fetch_vld` is 0 produces no reset request.
- R5: While `cfg_par_en` is 0, no reset request is produced, whatever the data. While it is 1, checking is active.
- R6: `perr_rst` is registered. It is 1 for exactly the one clock cycle that follows the rising edge at which a failing fetch was sampled. It then returns to 0 unless the next fetch also fails.
- R7: `perr_flag_clr` is 1 in exactly the cycles where `perr_rst` is 1.
- R8: While `rst_n` is low, and after its release until the first failing fetch, both outputs are 0.
- R9: The check detects one flipped bit in either lane, and it detects a flipped bit in each lane at the same time. Two flipped bits in the same lane leave that lane's parity unchanged and produce no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_vld | input | 1 | 1 when a fetched word is present this cycle |
| fetch_word | input | 14 | Fetched program word |
| par_even | input | 1 | Stored parity bit for the even-position lane (even sense) |
| par_odd | input | 1 | Stored parity bit for the odd-position lane (odd sense) |
| cfg_par_en | input | 1 | Configuration enable: 1 turns checking on, 0 turns it off |
| perr_rst | output | 1 | One-cycle parity-error reset request |
| perr_flag_clr | output | 1 | Strobe that drives the parity-error status flag to 0 |

## Verification
A lane that maps to the wrong bit positions, or uses the wrong parity sense, shows up at `perr_rst` one cycle after the first fetch it misjudges. A false request appears on a clean word, or an expected request is missing on a corrupted one. A gating fault in the fetch or enable qualification shows up just as quickly on the first invalid or disabled fetch that carries bad data. A stuck or stretched output register shows up in the second cycle after a failing fetch, when the pulse should already have dropped. The reset synchronizer shows its state at both outputs in the cycles right after `rst_n` is released.

// File: rtl/pwpar_pkg.sv
package pwpar_pkg;

  localparam int unsigned PW_W = 14;

  // Generator for stored parity bits: {odd_lane_bit, even_lane_bit}.
  function automatic logic [1:0] pw_gen_parity(input logic [PW_W-1:0] w);
    logic e;
    logic o;
    e = 1'b0;
    o = 1'b0;
    for (int i = 0; i < int'(PW_W); i++) begin
      if ((i % 2) == 0) e = e ^ w[i];
      else              o = o ^ w[i];
    end
    return {~o, e};
  endfunction

endpackage

// File: rtl/pwpar_rst_sync.sv
module pwpar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pwpar_lane.sv
module pwpar_lane #(
  parameter int unsigned WORD_W = 14,
  parameter int unsigned LANE   = 0,
  parameter bit          INV    = 1'b0
) (
  input  logic [WORD_W-1:0] word,
  input  logic              par_bit,
  output logic              lane_bad
);
  localparam int unsigned LBITS = (WORD_W - LANE + 1) / 2;

  logic [LBITS-1:0] lane_bits;
  logic             ref_bit;

  for (genvar i = 0; i < int'(LBITS); i++) begin : g_pick
    assign lane_bits[i] = word[2*i + LANE];
  end

  if (INV) begin : g_inv
    assign ref_bit = ~par_bit;
  end else begin : g_plain
    assign ref_bit = par_bit;
  end

  assign lane_bad = (^lane_bits) ^ ref_bit;
endmodule

// File: rtl/pwpar_check.sv
module pwpar_check
  import pwpar_pkg::*;
#(
  parameter int unsigned WORD_W = PW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              par_even,
  input  logic              par_odd,
  input  logic              cfg_par_en,
  output logic              perr_rst,
  output logic              perr_flag_clr
);
  logic rst_q_n;
  logic bad_even;
  logic bad_odd;
  logic chk_act;
  logic err_d;
  logic clr_d;
  logic err_q;
  logic clr_q;

  pwpar_rst_sync #(.STAGES(2)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q_n)
  );

  pwpar_lane #(.WORD_W(WORD_W), .LANE(0), .INV(1'b0)) u_even (
    .word     (fetch_word),
    .par_bit  (par_even),
    .lane_bad (bad_even)
  );

  pwpar_lane #(.WORD_W(WORD_W), .LANE(1), .INV(1'b1)) u_odd (
    .word     (fetch_word),
    .par_bit  (par_odd),
    .lane_bad (bad_odd)
  );

  always_comb begin
    chk_act = fetch_vld & cfg_par_en;
    err_d   = chk_act & (bad_even | bad_odd);
    clr_d   = err_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      err_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      err_q <= err_d;
      clr_q <= clr_d;
    end
  end

  assign perr_rst      = err_q;
  assign perr_flag_clr = clr_q;

  assert_no_req_without_fetch_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !fetch_vld |=> !perr_rst);

  assert_no_req_when_off_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cfg_par_en |=> !perr_rst);

  assert_clean_word_quiet_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!bad_even && !bad_odd) |=> !perr_rst);

  assert_clr_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    perr_rst |-> perr_flag_clr);

  assert_req_follows_clr_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    perr_flag_clr |-> perr_rst);

endmodule

// File: tb/pwpar_check_test.sv
module pwpar_check_test;
  logic        clk;
  logic        rst_n;
  logic        fetch_vld;
  logic [13:0] fetch_word;
  logic        par_even;
  logic        par_odd;
  logic        cfg_par_en;
  logic        perr_rst;
  logic        perr_flag_clr;

  int n_chk;
  int n_bad;
  bit done;

  pwpar_check uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_vld     (fetch_vld),
    .fetch_word    (fetch_word),
    .par_even      (par_even),
    .par_odd       (par_odd),
    .cfg_par_en    (cfg_par_en),
    .perr_rst      (perr_rst),
    .perr_flag_clr (perr_flag_clr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic tb_even(input logic [13:0] w);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 14; i += 2) r = r ^ w[i];
    return r;
  endfunction

  function automatic logic tb_odd(input logic [13:0] w);
    logic r;
    r = 1'b1;
    for (int i = 1; i < 14; i += 2) r = r ^ w[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // Present one fetch at a falling edge, then sample both outputs at the next falling edge.
  task automatic fetch(input logic [13:0] w, input logic pe, input logic po,
                       input logic vld, input logic en, input logic exp, input string tag);
    @(negedge clk);
    fetch_word = w; par_even = pe; par_odd = po; fetch_vld = vld; cfg_par_en = en;
    @(negedge clk);
    fetch_vld = 1'b0;
    check({tag, " req"}, perr_rst, exp);
    check({tag, " clr R7"}, perr_flag_clr, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; fetch_vld = 1'b0; fetch_word = '0; par_even = 1'b0; par_odd = 1'b0; cfg_par_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 in reset req", perr_rst, 1'b0);
    check("R8 in reset clr", perr_flag_clr, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 after release req", perr_rst, 1'b0);
    check("R8 after release clr", perr_flag_clr, 1'b0);
  endtask

  task automatic t_clean;
    logic [13:0] pats [5] = '{14'h0000, 14'h3FFF, 14'h2A55, 14'h15AA, 14'h1234};
    foreach (pats[k]) fetch(pats[k], tb_even(pats[k]), tb_odd(pats[k]), 1'b1, 1'b1, 1'b0, "R3 clean");
  endtask

  task automatic t_even_flip;
    for (int b = 0; b < 14; b += 2) begin
      logic [13:0] w;
      w = 14'h1234;
      fetch(w ^ (14'h1 << b), tb_even(w), tb_odd(w), 1'b1, 1'b1, 1'b1, "R1 even flip");
    end
    fetch(14'h2A55, ~tb_even(14'h2A55), tb_odd(14'h2A55), 1'b1, 1'b1, 1'b1, "R1 even par bit");
  endtask

  task automatic t_odd_flip;
    for (int b = 1; b < 14; b += 2) begin
      logic [13:0] w;
      w = 14'h15AA;
      fetch(w ^ (14'h1 << b), tb_even(w), tb_odd(w), 1'b1, 1'b1, 1'b1, "R2 odd flip");
    end
    fetch(14'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R2 odd sense zero word");
  endtask

  task automatic t_no_valid;
    fetch(14'h3FFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R4 invalid fetch");
  endtask

  task automatic t_disabled;
    fetch(14'h3FFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5 disabled");
    fetch(14'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 disabled both lanes");
    fetch(14'h0001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R5 re-enabled");
  endtask

  task automatic t_timing;
    @(negedge clk);
    fetch_word = 14'h0001; par_even = 1'b0; par_odd = 1'b1; fetch_vld = 1'b1; cfg_par_en = 1'b1;
    @(negedge clk);
    check("R6 first bad pulse", perr_rst, 1'b1);
    fetch_word = 14'h0002; par_even = 1'b0; par_odd = 1'b1;
    @(negedge clk);
    check("R6 back-to-back pulse", perr_rst, 1'b1);
    check("R7 back-to-back clr", perr_flag_clr, 1'b1);
    fetch_word = 14'h0000; par_even = 1'b0; par_odd = 1'b1;
    @(negedge clk);
    check("R6 drop after clean", perr_rst, 1'b0);
    fetch_vld = 1'b0;
    fetch_word = 14'h0001;
    @(negedge clk);
    check("R6 stays low", perr_rst, 1'b0);
    check("R7 stays low", perr_flag_clr, 1'b0);
  endtask

  task automatic t_double;
    logic [13:0] w;
    w = 14'h2A55;
    fetch(w ^ 14'h0005, tb_even(w), tb_odd(w), 1'b1, 1'b1, 1'b0, "R9 two even flips");
    fetch(w ^ 14'h000A, tb_even(w), tb_odd(w), 1'b1, 1'b1, 1'b0, "R9 two odd flips");
    fetch(w ^ 14'h0003, tb_even(w), tb_odd(w), 1'b1, 1'b1, 1'b1, "R9 one flip per lane");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    t_reset;
    t_clean;
    t_even_flip;
    t_odd_flip;
    t_no_valid;
    t_disabled;
    t_timing;
    t_double;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule